// File: doc/BRIEF.md
# Flow-through synchronous SRAM with zero bus turnaround

This block models a single-clock synchronous SRAM whose data bus is shared by reads and writes. It accepts a new access on every enabled rising edge, in any mix of reads and writes, and needs no idle cycle between them. A read is flow-through: the word addressed at one edge is presented during the very next cycle, with no output register. A write is late: its address and controls are taken at one edge, and its data is taken from the bus at the next enabled edge. The output drivers stay off during that data cycle so that the bus does not contend.

A one-word write buffer holds the most recently captured write until the following enabled edge commits it to the array. Reads that hit a write whose data is pending or just captured get the newest data, merged lane by lane under that write's byte selects. An active-low clock enable freezes every register, which stretches the current cycle. An advance/load input either starts a new access or steps a four-beat burst. The burst steps through the two low address bits in linear or interleaved order. An asynchronous output enable gates only the drivers. The depth is set by the address-width parameter.

Top module: `flowthru_sram`

## Requirements
- R1: While `rst_n` is low and after it rises, with no access loaded, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: A load (`adv_ld`=0) starts an access only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. If any one of them is inactive, the cycle is a deselect: the bus is not driven in the following cycle and the array is not written.
- R3: A selected load with `we_n`=1 at edge k drives the addressed word on `dq_out`, with `dq_oe`=1 (given `oe_n`=0), during the cycle that directly follows edge k.
- R4: A selected load with `we_n`=0 at edge k takes its data from `dq_in` at the next enabled edge. During the cycle between those edges, `dq_oe` is 0.
- R5: `bw_n[0]`=0 enables writing bits [8:0] and `bw_n[1]`=0 enables writing bits [17:9]. A lane whose select is 1 keeps its previous content. With both selects at 1, the word is unchanged.
- R6: Reads and writes can follow each other on consecutive enabled edges in any mix. A read of an address whose write data is pending or was just captured returns that newest data.
- R7: With `cen_n`=1, an edge is ignored. The loaded access, the bus state and `dq_out` stay as they were, and `dq_in` is not sampled at that edge.
- R8: `oe_n`=1 forces `dq_oe` to 0 without a clock and without changing the access in progress. Dropping `oe_n` within the cycle drives the read word at once.
- R9: With `burst_lin`=1, the n-th advance (`adv_ld`=1) after a load at address S accesses the address whose two low bits are (S[1:0]+n) mod 4.
- R10: With `burst_lin`=0, the n-th advance accesses the address whose two low bits are S[1:0] XOR n.
- R11: An advance continues the loaded access type, read or write. It ignores the chip enables and `we_n`, but it samples `bw_n`. An advance that follows a deselect is also a deselect.
- R12: A burst wraps within its aligned four-word block, and the address bits above bit 1 stay those of the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Clock enable, active low; 1 freezes the block |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable on a load, active low |
| bw_n | input | 2 | Lane write selects, active low; bit 0 covers data bits [8:0] |
| adv_ld | input | 1 | 0 loads a new access, 1 advances the burst |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 18 | Data bus as seen entering the block |
| dq_out | output | 18 | Data driven onto the bus |
| dq_oe | output | 1 | Drive enable for `dq_out` |

## Verification
The bench reads an address on the edge right after its write, and again on the edge after that. This finds a design that returns stale array data when the write is still in the buffer, or that loses data when the buffer commits. It writes with partial lane selects and checks the lane that should be preserved, which catches swapped lanes or selects of the wrong polarity. It stalls during both a read and a write data phase and drives garbage on `dq_in` during the stall. A design that samples at a frozen edge then stores the garbage. It runs bursts from unaligned start addresses in both orders, checking the wrap and that advances ignore the chip enables. A counter that confused add with XOR, or that escaped the four-word block, returns the wrong words.

// File: rtl/flowthru_sram_pkg.sv
package flowthru_sram_pkg;
    localparam int LANE_W  = 9;
    localparam int LANES   = 2;
    localparam int WORD_W  = LANE_W * LANES;
    localparam int BURST_W = 2;
endpackage

// File: rtl/flowthru_burst_step.sv
module flowthru_burst_step
    import flowthru_sram_pkg::*;
(
    input  logic [BURST_W-1:0] start,
    input  logic [BURST_W-1:0] count,
    input  logic               linear,
    output logic [BURST_W-1:0] offset
);
    always_comb begin
        if (linear) begin
            offset = start + count;
        end else begin
            offset = start ^ count;
        end
    end
endmodule

// File: rtl/flowthru_array.sv
module flowthru_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES-1:0]         wr_lanes,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end
endmodule

// File: rtl/flowthru_lane_merge.sv
module flowthru_lane_merge #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] base,
    input  logic [LANES*LANE_W-1:0] upd,
    input  logic [LANES-1:0]        take,
    output logic [LANES*LANE_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_mrg
        assign merged[g*LANE_W +: LANE_W] =
            take[g] ? upd[g*LANE_W +: LANE_W] : base[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/flowthru_sram.sv
module flowthru_sram
    import flowthru_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              adv_ld,
    input  logic              burst_lin,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe
);
    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
        logic               bact;
        logic               bwr;
        logic               rd_valid;
        logic               wr_pend;
        logic [ADDR_W-1:0]  acc_addr;
        logic [LANES-1:0]   acc_bw;
        logic               buf_valid;
        logic [ADDR_W-1:0]  buf_addr;
        logic [LANES-1:0]   buf_bw;
        logic [WORD_W-1:0]  buf_data;
    } state_t;

    state_t st_d, st_q;

    logic               sel;
    logic [BURST_W-1:0] cnt_nxt;
    logic [BURST_W-1:0] step_lo;
    logic [WORD_W-1:0]  arr_rd;
    logic [WORD_W-1:0]  merged;
    logic               buf_hit;

    // Signals brought out for the bound checker.
    logic [ADDR_W-1:0]  cur_addr;
    logic               cur_rd;
    logic               cur_wr;
    logic               buf_vld;
    logic               burst_on;

    assign sel     = ~ce1_n & ce2 & ~ce3_n;
    assign cnt_nxt = st_q.cnt + BURST_W'(1);

    flowthru_burst_step u_step (
        .start  (st_q.base[BURST_W-1:0]),
        .count  (cnt_nxt),
        .linear (burst_lin),
        .offset (step_lo)
    );

    flowthru_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk      (clk),
        .wr_en    (~cen_n & st_q.buf_valid),
        .wr_addr  (st_q.buf_addr),
        .wr_lanes (st_q.buf_bw),
        .wr_data  (st_q.buf_data),
        .rd_addr  (st_q.acc_addr),
        .rd_data  (arr_rd)
    );

    assign buf_hit = st_q.buf_valid && (st_q.buf_addr == st_q.acc_addr);

    flowthru_lane_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_merge (
        .base   (arr_rd),
        .upd    (st_q.buf_data),
        .take   (buf_hit ? st_q.buf_bw : '0),
        .merged (merged)
    );

    always_comb begin
        st_d = st_q;
        if (!cen_n) begin
            // Data phase of the write loaded at the previous enabled edge.
            st_d.buf_valid = st_q.wr_pend;
            if (st_q.wr_pend) begin
                st_d.buf_addr = st_q.acc_addr;
                st_d.buf_bw   = st_q.acc_bw;
                st_d.buf_data = dq_in;
            end
            st_d.acc_bw = ~bw_n;
            if (!adv_ld) begin
                st_d.base     = addr;
                st_d.cnt      = '0;
                st_d.bact     = sel;
                st_d.bwr      = ~we_n;
                st_d.acc_addr = addr;
                st_d.rd_valid = sel & we_n;
                st_d.wr_pend  = sel & ~we_n;
            end else if (st_q.bact) begin
                st_d.cnt      = cnt_nxt;
                st_d.acc_addr = {st_q.base[ADDR_W-1:BURST_W], step_lo};
                st_d.rd_valid = ~st_q.bwr;
                st_d.wr_pend  = st_q.bwr;
            end else begin
                st_d.rd_valid = 1'b0;
                st_d.wr_pend  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out = st_q.rd_valid ? merged : '0;
    assign dq_oe  = st_q.rd_valid & ~oe_n;

    assign cur_addr = st_q.acc_addr;
    assign cur_rd   = st_q.rd_valid;
    assign cur_wr   = st_q.wr_pend;
    assign buf_vld  = st_q.buf_valid;
    assign burst_on = st_q.bact;
endmodule

// File: rtl/flowthru_sram_chk.sv
module flowthru_sram_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              we_n,
    input logic              adv_ld,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              cur_rd,
    input logic              cur_wr,
    input logic              buf_vld,
    input logic              burst_on
);
    logic chip_on;
    assign chip_on = ~ce1_n & ce2 & ~ce3_n;

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && !chip_on) |=> !dq_oe); // R2

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && chip_on && we_n) |=> (dq_oe || oe_n)); // R3

    AST_WRITE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && chip_on && !we_n) |=> !dq_oe); // R4

    AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && cur_wr) |=> buf_vld); // R4

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(cur_addr) && $stable(cur_rd) && $stable(cur_wr) && $stable(buf_vld))); // R7

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && burst_on) |=>
        ((cur_addr[1:0] != $past(cur_addr[1:0])) &&
         (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])))); // R12
endmodule

bind flowthru_sram flowthru_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cen_n    (cen_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .we_n     (we_n),
    .adv_ld   (adv_ld),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .cur_addr (cur_addr),
    .cur_rd   (cur_rd),
    .cur_wr   (cur_wr),
    .buf_vld  (buf_vld),
    .burst_on (burst_on)
);

// File: tb/test_flowthru_sram.sv
`timescale 1ns/1ps
module test_flowthru_sram;
    localparam logic [2:0] SEL   = 3'b010; // {ce1_n, ce2, ce3_n}
    localparam logic [2:0] NOSEL = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cen_n = 1'b0;
    logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic        we_n = 1'b1;
    logic [1:0]  bw_n = 2'b11;
    logic        adv_ld = 1'b0;
    logic        burst_lin = 1'b1;
    logic [7:0]  addr = '0;
    logic        oe_n = 1'b0;
    logic [17:0] dq_in = '0;
    logic [17:0] dq_out;
    logic        dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [17:0] model [256];

    always #4 clk = ~clk;

    flowthru_sram i_flowthru_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n), .adv_ld(adv_ld),
        .burst_lin(burst_lin), .addr(addr), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Applies one cycle of inputs at a falling edge and returns at the next one.
    task automatic drive(input logic ld, input logic [2:0] ce, input logic wr,
                         input logic [1:0] bwn, input logic [7:0] a, input logic [17:0] d);
        cen_n  = 1'b0;
        adv_ld = ~ld;
        {ce1_n, ce2, ce3_n} = ce;
        we_n   = ~wr;
        bw_n   = bwn;
        addr   = a;
        dq_in  = d;
        @(negedge clk);
    endtask

    task automatic stall(input logic [17:0] d);
        cen_n = 1'b1;
        adv_ld = 1'b0;
        {ce1_n, ce2, ce3_n} = SEL;
        we_n  = 1'b0;
        addr  = 8'hEE;
        dq_in = d;
        @(negedge clk);
    endtask

    task automatic write_one(input logic [7:0] a, input logic [17:0] d);
        drive(1'b1, SEL, 1'b1, 2'b00, a, 18'h0);
        drive(1'b1, NOSEL, 1'b0, 2'b11, 8'h00, d);
        model[a] = d;
    endtask

    task automatic t_reset();
        chk("R1 oe", {17'h0, dq_oe}, 18'h0);
        chk("R1 data", dq_out, 18'h0);
    endtask

    task automatic t_back_to_back();
        drive(1'b1, SEL, 1'b1, 2'b00, 8'h10, 18'h0);
        chk("R4 bus off in data phase", {17'h0, dq_oe}, 18'h0);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h10, 18'h2A5A5);
        model[8'h10] = 18'h2A5A5;
        chk("R3 read drives", {17'h0, dq_oe}, 18'h1);
        chk("R6 read of just-written", dq_out, model[8'h10]);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h10, 18'h0);
        chk("R3 read from array", dq_out, model[8'h10]);
        drive(1'b1, SEL, 1'b1, 2'b00, 8'h11, 18'h0);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h10, 18'h1C3C3);
        model[8'h11] = 18'h1C3C3;
        chk("R6 read between writes", dq_out, model[8'h10]);
        drive(1'b1, SEL, 1'b1, 2'b00, 8'h12, 18'h0);
        chk("R6 write after read", {17'h0, dq_oe}, 18'h0);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h11, 18'h05A5A);
        model[8'h12] = 18'h05A5A;
        chk("R6 mixed read 0x11", dq_out, model[8'h11]);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h12, 18'h0);
        chk("R6 mixed read 0x12", dq_out, model[8'h12]);
    endtask

    task automatic t_lanes();
        drive(1'b1, SEL, 1'b1, 2'b10, 8'h10, 18'h0);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h10, 18'h3FFFF);
        model[8'h10] = (model[8'h10] & 18'h3FE00) | 18'h001FF;
        chk("R5 low lane only", dq_out, model[8'h10]);
        drive(1'b1, SEL, 1'b1, 2'b01, 8'h10, 18'h0);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h10, 18'h00000);
        model[8'h10] = model[8'h10] & 18'h001FF;
        chk("R5 high lane only", dq_out, model[8'h10]);
        drive(1'b1, SEL, 1'b1, 2'b11, 8'h10, 18'h0);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h10, 18'h12345);
        chk("R5 no lane", dq_out, model[8'h10]);
    endtask

    task automatic t_select();
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, SEL ^ (3'b001 << i), 1'b0, 2'b00, 8'h10, 18'h0);
            chk("R2 deselect read", {17'h0, dq_oe}, 18'h0);
            drive(1'b1, SEL ^ (3'b001 << i), 1'b1, 2'b00, 8'h10, 18'h0);
            drive(1'b1, NOSEL, 1'b0, 2'b11, 8'h00, 18'h3ABCD);
        end
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h10, 18'h0);
        chk("R2 deselected write ignored", dq_out, model[8'h10]);
    endtask

    task automatic t_stall();
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h11, 18'h0);
        stall(18'h0);
        chk("R7 stall keeps data", dq_out, model[8'h11]);
        chk("R7 stall keeps drive", {17'h0, dq_oe}, 18'h1);
        drive(1'b1, SEL, 1'b1, 2'b00, 8'h20, 18'h0);
        stall(18'h3FFFF);
        chk("R7 stall in data phase", {17'h0, dq_oe}, 18'h0);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h20, 18'h0ABCD);
        model[8'h20] = 18'h0ABCD;
        chk("R7 data taken after stall", dq_out, model[8'h20]);
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h12, 18'h0);
        chk("R8 oe_n high", {17'h0, dq_oe}, 18'h0);
        oe_n = 1'b0;
        #1;
        chk("R8 oe_n falls", {17'h0, dq_oe}, 18'h1);
        chk("R8 data kept", dq_out, model[8'h12]);
        @(negedge clk);
    endtask

    task automatic t_burst_read(input logic lin, input logic [7:0] start);
        burst_lin = lin;
        drive(1'b1, SEL, 1'b0, 2'b00, start, 18'h0);
        chk(lin ? "R9 burst first" : "R10 burst first", dq_out, model[start]);
        for (int k = 1; k < 4; k++) begin
            logic [1:0] lo;
            lo = lin ? 2'(start[1:0] + 2'(k)) : (start[1:0] ^ 2'(k));
            drive(1'b0, NOSEL, 1'b1, 2'b00, 8'hFF, 18'h0);
            chk(lin ? "R9 linear step" : "R10 interleaved step", dq_out,
                model[{start[7:2], lo}]);
            chk("R12 read beat driven", {17'h0, dq_oe}, 18'h1);
        end
    endtask

    task automatic t_burst_write();
        burst_lin = 1'b1;
        drive(1'b1, SEL, 1'b1, 2'b00, 8'h4A, 18'h0);
        drive(1'b0, NOSEL, 1'b0, 2'b00, 8'h00, 18'h11111);
        chk("R11 write burst continues", {17'h0, dq_oe}, 18'h0);
        drive(1'b0, NOSEL, 1'b0, 2'b00, 8'h00, 18'h22222);
        drive(1'b0, NOSEL, 1'b0, 2'b00, 8'h00, 18'h33333);
        drive(1'b1, SEL, 1'b0, 2'b00, 8'h4A, 18'h04444);
        model[8'h4A] = 18'h11111; model[8'h4B] = 18'h22222;
        model[8'h48] = 18'h33333; model[8'h49] = 18'h04444;
        chk("R11 burst write beat 0", dq_out, model[8'h4A]);
        drive(1'b0, NOSEL, 1'b1, 2'b00, 8'h00, 18'h0);
        chk("R11 burst write beat 1", dq_out, model[8'h4B]);
        drive(1'b0, NOSEL, 1'b1, 2'b00, 8'h00, 18'h0);
        chk("R12 burst wrap", dq_out, model[8'h48]);
        drive(1'b0, NOSEL, 1'b1, 2'b00, 8'h00, 18'h0);
        chk("R11 burst write beat 3", dq_out, model[8'h49]);
        drive(1'b1, NOSEL, 1'b0, 2'b00, 8'h48, 18'h0);
        drive(1'b0, SEL, 1'b0, 2'b00, 8'h48, 18'h0);
        chk("R11 advance after deselect", {17'h0, dq_oe}, 18'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_back_to_back();
        t_lanes();
        t_select();
        t_stall();
        t_oe();
        for (int i = 0; i < 4; i++) begin
            write_one(8'h40 + 8'(i), 18'h00100 + 18'(i * 18'h01011));
        end
        t_burst_read(1'b1, 8'h41);
        t_burst_read(1'b0, 8'h42);
        t_burst_read(1'b0, 8'h41);
        t_burst_write();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule